// File: doc/BRIEF.md
# Selectable Hardware/Software Clock Gate Controller

This block owns the gate control for one clock. A small control register holds a software enable bit and a mode select bit. The select bit chooses the source of the gate command. In hardware mode the gate follows an auto-gating request input. In software mode it follows the enable bit. The block drives a clock-enable output, which stands in for a cell-level gating cell, and reports the real gate state through a read-only status bit.

The gate does not react at once. The effective command passes through a settle stage, so the gate state and the status bit trail the command by a fixed number of cycles. Software that changes the gate must poll the status bit until it shows the new state.

A compile-time kind parameter gives four variants: no gate at all, hardware-only, software-only, or selectable. A second parameter marks a gate as one that must never be switched off under software control. A third parameter chooses whether a selectable gate comes out of reset in software mode.

Top module: `clkgate_ctl`

## Requirements
- R1: After reset, a selectable gate with software start reads enable=1, select=1 and status=1, and `clk_en` is 1. A software-only gate reads 3'b111 and a hardware-only gate reads 3'b000. Read layout: bit 0 is enable, bit 1 is select (1 = software, 0 = hardware), bit 2 is status.
- R2: In software mode the gate follows the enable bit, where 1 turns the clock on and 0 turns it off. The hardware request has no effect in this mode. Write layout: bit 0 is enable, bit 1 is select.
- R3: In hardware mode (select = 0) the gate follows `hw_req`.
- R4: `clk_en` and the status bit change exactly SETTLE cycles (default 4) after the effective command changes. Until then they keep the old value. When the inputs have been steady for SETTLE cycles, they equal the command.
- R5: The status bit always equals `clk_en`, in either mode.
- R6: With no gate, `clk_en` and the status bit are always 1, whatever is written and whatever `hw_req` does.
- R7: A no-disable gate stays on while in software mode, even with enable = 0. In hardware mode it can still be switched off.
- R8: On a hardware-only gate, the enable and select bits read as 0 and writes to them have no effect. The gate follows `hw_req`.
- R9: On a software-only gate, select reads as 1 and cannot be changed, and `hw_req` has no effect.
- R10: Writing the select bit hands control between hardware and software. After the settle delay, the gate follows the new source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 2 | Write data: bit 0 enable, bit 1 select |
| hw_req | input | 1 | Hardware auto-gating request (1 = clock wanted) |
| rd_data | output | 3 | Read data: bit 0 enable, bit 1 select, bit 2 status |
| clk_en | output | 1 | Settled gate state, used as the clock enable |

## Verification
Software mode is tried with the enable bit toggled while `hw_req` is driven against it. A gate that wrongly listens to hardware is then told apart from one that follows software. Hardware mode and both directions of handover are tried with `hw_req` pulses and with writes that move the select bit in each direction, starting from both gate states. Every change is sampled one cycle before and one cycle at the settle boundary, which separates an exact delay from one cycle early or one cycle late. Separate instances cover the hardware-only, software-only, no-gate and no-disable variants, using writes that those variants must ignore.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

    typedef enum logic [1:0] {
        GATE_NONE       = 2'd0,
        GATE_HW_ONLY    = 2'd1,
        GATE_SW_ONLY    = 2'd2,
        GATE_SELECTABLE = 2'd3
    } gate_kind_e;

    localparam int CTRL_W   = 2;
    localparam int READ_W   = 3;
    localparam int EN_BIT   = 0;
    localparam int SEL_BIT  = 1;
    localparam int STAT_BIT = 2;

    typedef struct packed {
        logic sel;
        logic en;
    } gate_ctrl_t;

endpackage

// File: rtl/clkgate_regs.sv
module clkgate_regs
    import clkgate_pkg::*;
#(
    parameter gate_kind_e KIND   = GATE_SELECTABLE,
    parameter bit         INIT_SW = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output gate_ctrl_t        ctrl
);
    localparam bit HAS_EN  = (KIND == GATE_SW_ONLY) || (KIND == GATE_SELECTABLE);
    localparam bit HAS_SEL = (KIND == GATE_SELECTABLE);
    localparam bit RST_SEL = (KIND == GATE_SW_ONLY) ? 1'b1 :
                             (KIND == GATE_SELECTABLE) ? INIT_SW : 1'b0;

    gate_ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) begin
            if (HAS_EN) begin
                ctrl_d.en = wr_data[EN_BIT];
            end
            if (HAS_SEL) begin
                ctrl_d.sel = wr_data[SEL_BIT];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q.en  <= HAS_EN;
            ctrl_q.sel <= RST_SEL;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ctrl = ctrl_q;

endmodule

// File: rtl/clkgate_mux.sv
module clkgate_mux
    import clkgate_pkg::*;
#(
    parameter gate_kind_e KIND       = GATE_SELECTABLE,
    parameter bit         NO_DISABLE = 1'b0
) (
    input  gate_ctrl_t ctrl,
    input  logic       hw_req,
    output logic       cmd
);
    logic sw_cmd;

    always_comb begin
        sw_cmd = ctrl.en | NO_DISABLE;
        case (KIND)
            GATE_NONE:       cmd = 1'b1;
            GATE_HW_ONLY:    cmd = hw_req;
            GATE_SW_ONLY:    cmd = sw_cmd;
            default:         cmd = ctrl.sel ? sw_cmd : hw_req;
        endcase
    end

endmodule

// File: rtl/clkgate_settle.sv
module clkgate_settle #(
    parameter int SETTLE  = 4,
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd,
    output logic state
);
    logic [SETTLE-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d    = pipe_q << 1;
        pipe_d[0] = cmd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= {SETTLE{RST_VAL}};
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign state = pipe_q[SETTLE-1];

endmodule

// File: rtl/clkgate_ctl.sv
module clkgate_ctl
    import clkgate_pkg::*;
#(
    parameter gate_kind_e KIND       = GATE_SELECTABLE,
    parameter bit         NO_DISABLE = 1'b0,
    parameter bit         INIT_SW    = 1'b1,
    parameter int         SETTLE     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              hw_req,
    output logic [READ_W-1:0] rd_data,
    output logic              clk_en
);
    // Reset value of the settle stage equals the command implied by the reset register state.
    localparam bit RST_GATE = (KIND == GATE_NONE)       ? 1'b1 :
                              (KIND == GATE_SW_ONLY)    ? 1'b1 :
                              (KIND == GATE_SELECTABLE) ? (INIT_SW | NO_DISABLE & INIT_SW) :
                              1'b0;

    gate_ctrl_t ctrl;
    logic       cmd;
    logic       gate;

    clkgate_regs #(.KIND(KIND), .INIT_SW(INIT_SW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl    (ctrl)
    );

    clkgate_mux #(.KIND(KIND), .NO_DISABLE(NO_DISABLE)) u_mux (
        .ctrl    (ctrl),
        .hw_req  (hw_req),
        .cmd     (cmd)
    );

    clkgate_settle #(.SETTLE(SETTLE), .RST_VAL(RST_GATE)) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (cmd),
        .state   (gate)
    );

    always_comb begin
        rd_data           = '0;
        rd_data[EN_BIT]   = ctrl.en;
        rd_data[SEL_BIT]  = ctrl.sel;
        rd_data[STAT_BIT] = gate;
    end

    assign clk_en = gate;

endmodule

// File: rtl/clkgate_chk.sv
module clkgate_chk
    import clkgate_pkg::*;
#(
    parameter gate_kind_e KIND       = GATE_SELECTABLE,
    parameter bit         NO_DISABLE = 1'b0,
    parameter int         SETTLE     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hw_req,
    input logic [READ_W-1:0] rd_data,
    input logic              clk_en
);
    localparam int CW = $clog2(SETTLE + 1) + 1;

    logic [2:0]    cur;
    logic [2:0]    prev_q;
    logic          prev_ok_q;
    logic [CW-1:0] cnt_q;
    logic          steady;
    logic          sw_mode;
    logic          hw_mode;

    assign cur = {hw_req, rd_data[SEL_BIT], rd_data[EN_BIT]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q    <= '0;
            prev_ok_q <= 1'b0;
            cnt_q     <= '0;
        end else begin
            prev_q    <= cur;
            prev_ok_q <= 1'b1;
            if (prev_ok_q && (cur == prev_q)) begin
                if (cnt_q < CW'(SETTLE)) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                cnt_q <= '0;
            end
        end
    end

    always_comb begin
        steady  = prev_ok_q && (cur == prev_q) && (cnt_q >= CW'(SETTLE));
        sw_mode = (KIND == GATE_SW_ONLY) || ((KIND == GATE_SELECTABLE) && rd_data[SEL_BIT]);
        hw_mode = (KIND == GATE_HW_ONLY) || ((KIND == GATE_SELECTABLE) && !rd_data[SEL_BIT]);
    end

    AST_SW_FOLLOWS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (steady && sw_mode && !NO_DISABLE) |-> (clk_en == rd_data[EN_BIT])); // R2
    AST_HW_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (steady && hw_mode) |-> (clk_en == hw_req)); // R3
    AST_CHANGE_NEEDS_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en != $past(clk_en)) |-> (cnt_q < CW'(SETTLE))); // R4
    AST_STATUS_IS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[STAT_BIT] == clk_en); // R5
    AST_NOGATE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (KIND == GATE_NONE) |-> (clk_en && rd_data[STAT_BIT])); // R6
    AST_NODIS_STAYS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (steady && sw_mode && NO_DISABLE) |-> clk_en); // R7
    AST_HWONLY_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (KIND == GATE_HW_ONLY) |-> (rd_data[SEL_BIT:EN_BIT] == 2'b00)); // R8
    AST_SWONLY_SEL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (KIND == GATE_SW_ONLY) |-> rd_data[SEL_BIT]); // R9

endmodule

bind clkgate_ctl clkgate_chk #(
    .KIND       (KIND),
    .NO_DISABLE (NO_DISABLE),
    .SETTLE     (SETTLE)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .hw_req  (hw_req),
    .rd_data (rd_data),
    .clk_en  (clk_en)
);

// File: tb/test_clkgate_ctl.sv
`timescale 1ns/1ps
module test_clkgate_ctl;
    import clkgate_pkg::*;

    localparam int NDUT = 5;  // 0 selectable, 1 hw-only, 2 no gate, 3 no-disable, 4 sw-only

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] wr_data;
    logic       hw_req;
    logic       wr_v  [NDUT];
    logic [2:0] rdat  [NDUT];
    logic       gate  [NDUT];

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;

    clkgate_ctl #(.KIND(GATE_SELECTABLE), .NO_DISABLE(1'b0), .INIT_SW(1'b1)) i_clkgate_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_v[0]), .wr_data(wr_data),
        .hw_req(hw_req), .rd_data(rdat[0]), .clk_en(gate[0]));
    clkgate_ctl #(.KIND(GATE_HW_ONLY)) i_hwonly (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_v[1]), .wr_data(wr_data),
        .hw_req(hw_req), .rd_data(rdat[1]), .clk_en(gate[1]));
    clkgate_ctl #(.KIND(GATE_NONE)) i_nogate (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_v[2]), .wr_data(wr_data),
        .hw_req(hw_req), .rd_data(rdat[2]), .clk_en(gate[2]));
    clkgate_ctl #(.KIND(GATE_SELECTABLE), .NO_DISABLE(1'b1), .INIT_SW(1'b0)) i_nodis (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_v[3]), .wr_data(wr_data),
        .hw_req(hw_req), .rd_data(rdat[3]), .clk_en(gate[3]));
    clkgate_ctl #(.KIND(GATE_SW_ONLY)) i_swonly (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_v[4]), .wr_data(wr_data),
        .hw_req(hw_req), .rd_data(rdat[4]), .clk_en(gate[4]));

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input int idx, input logic [1:0] d);
        @(negedge clk);
        wr_data   = d;
        wr_v[idx] = 1'b1;
        @(negedge clk);
        wr_v[idx] = 1'b0;
    endtask

    // Called at the negedge right after the command changed: four samples old, fifth new (R4).
    task automatic settle_chk(input int idx, input logic oldv, input logic newv, input string req);
        chk({req, " R4 hold"}, gate[idx], oldv);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk({req, " R4 hold"}, gate[idx], oldv);
            chk("R5 status", rdat[idx][2], gate[idx]);
        end
        @(negedge clk);
        chk({req, " R4 settled"}, gate[idx], newv);
        chk("R5 status", rdat[idx][2], newv);
    endtask

    task automatic t_reset;
        chk("R1 selectable read", rdat[0], 3'b111);
        chk("R1 selectable gate", gate[0], 1);
        chk("R1 hw-only read", rdat[1], 3'b000);
        chk("R1 sw-only read", rdat[4], 3'b111);
        chk("R6 no gate status", rdat[2][2], 1);
    endtask

    task automatic t_sw_mode;
        wr(0, 2'b10);
        settle_chk(0, 1'b1, 1'b0, "R2 off");
        wr(0, 2'b11);
        settle_chk(0, 1'b0, 1'b1, "R2 on");
        hw_req = 1'b0;
        wait_cyc(6);
        chk("R2 hw ignored (en=1)", gate[0], 1);
        wr(0, 2'b10);
        wait_cyc(6);
        hw_req = 1'b1;
        wait_cyc(6);
        chk("R2 hw ignored (en=0)", gate[0], 0);
        hw_req = 1'b0;
        wr(0, 2'b11);
        wait_cyc(6);
    endtask

    task automatic t_handover;
        hw_req = 1'b0;
        wait_cyc(2);
        wr(0, 2'b00);
        settle_chk(0, 1'b1, 1'b0, "R10 to hw");
        chk("R10 select reads hw", rdat[0][1], 0);
        hw_req = 1'b1;
        settle_chk(0, 1'b0, 1'b1, "R3 req on");
        hw_req = 1'b0;
        settle_chk(0, 1'b1, 1'b0, "R3 req off");
        wr(0, 2'b11);
        settle_chk(0, 1'b0, 1'b1, "R10 to sw on");
        wr(0, 2'b01);
        hw_req = 1'b1;
        wait_cyc(6);
        chk("R3 hw on", gate[0], 1);
        wr(0, 2'b10);
        settle_chk(0, 1'b1, 1'b0, "R10 to sw off");
        hw_req = 1'b0;
    endtask

    task automatic t_nodis;
        hw_req = 1'b0;
        wait_cyc(6);
        chk("R7 hw off", gate[3], 0);
        wr(3, 2'b10);
        settle_chk(3, 1'b0, 1'b1, "R7 sw forces on");
        wait_cyc(5);
        chk("R7 stays on", gate[3], 1);
        wr(3, 2'b00);
        settle_chk(3, 1'b1, 1'b0, "R7 hw can disable");
    endtask

    task automatic t_hwonly;
        hw_req = 1'b0;
        wait_cyc(6);
        wr(1, 2'b11);
        chk("R8 bits read zero", rdat[1][1:0], 0);
        wait_cyc(5);
        chk("R8 write ignored", gate[1], 0);
        hw_req = 1'b1;
        settle_chk(1, 1'b0, 1'b1, "R8 follows req");
        hw_req = 1'b0;
        settle_chk(1, 1'b1, 1'b0, "R8 follows req");
    endtask

    task automatic t_swonly;
        hw_req = 1'b1;
        wait_cyc(6);
        wr(4, 2'b01);
        chk("R9 select stuck at 1", rdat[4][1], 1);
        wait_cyc(5);
        chk("R9 gate on", gate[4], 1);
        wr(4, 2'b10);
        settle_chk(4, 1'b1, 1'b0, "R9 sw off");
        hw_req = 1'b0;
        wait_cyc(3);
        hw_req = 1'b1;
        wait_cyc(6);
        chk("R9 hw ignored", gate[4], 0);
        wr(4, 2'b11);
        settle_chk(4, 1'b0, 1'b1, "R9 sw on");
    endtask

    task automatic t_nogate;
        wr(2, 2'b00);
        for (int i = 0; i < 6; i++) begin
            hw_req = i[0];
            @(negedge clk);
            chk("R6 gate on", gate[2], 1);
            chk("R6 status on", rdat[2][2], 1);
        end
    endtask

    initial begin
        rst_n   = 1'b0;
        hw_req  = 1'b0;
        wr_data = 2'b00;
        for (int i = 0; i < NDUT; i++) wr_v[i] = 1'b0;
        wait_cyc(3);
        rst_n = 1'b1;
        t_reset();
        t_sw_mode();
        t_handover();
        t_nodis();
        t_hwonly();
        t_swonly();
        t_nogate();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule